// File: doc/BRIEF.md
# Inter-Processor Mailbox and Doorbell Hub

This block lets a group of processors signal each other. Each processor owns a message queue of 16-bit words. Any processor may push a word into any queue, but only the owner can pop its own. The owner's interrupt line stays high while its queue holds data. A second path is the doorbell. A processor writes one encoded byte that names a target processor and an interrupt number. The hub then latches that bit in the target's status word. The target clears the bit by writing a one to it.

Every processor has its own request lane. The lanes carry a valid strobe, a write flag, a register address and write data. A fixed-priority arbiter picks one lane per cycle. The winning lane drives a single internal register port, tagged with the winner's index. The chosen lane sees its grant in the same cycle. Its read response arrives on a shared data bus one cycle later, with a per-processor response strobe. Lanes that lose keep their request up until they are granted.

Register addresses seen by processor p: 0 to N_PROC-1 select the mailbox of that index, 8 is the doorbell, 9 is p's own doorbell status, and 10 is p's own mailbox overflow flag.

Top module: `ipc_mailbox_hub`

## Requirements
- R1: When several lanes request in the same cycle, exactly one is granted: the one with the lowest index. The others see no grant and are served in later cycles, in index order, while they hold their request.
- R2: A granted write to address k (k below N_PROC) from any processor appends the low 16 bits of write data to mailbox k. Each mailbox holds up to 32 words.
- R3: A granted read from address k by processor k pops the oldest word of mailbox k. The word appears on the response bus one cycle after the grant, together with that processor's response strobe. Words come out in write order.
- R4: A read of mailbox k by any processor other than k returns zero and leaves mailbox k unchanged.
- R5: A write to a full mailbox is discarded and sets that mailbox's sticky overflow flag. The owner reads the flag at address 10, bit 0. The owner clears it by writing 1 to bit 0 at address 10. The flag stays set through later pops.
- R6: The interrupt output of processor p is high from the cycle after a write lands in mailbox p, and for as long as that mailbox is not empty.
- R7: A write to address 8 takes bits 5:3 as a target code and bits 2:0 as an interrupt number n. Codes 1 to 5 select processors 0 to 4, so code 1 means processor 0. The write sets bit n of the target's 8-bit status. Bits 7:6 have no effect.
- R8: Doorbell writes with target code 0, 6 or 7 change no status bit and raise no interrupt.
- R9: A read of address 9 returns the requester's own status in bits 7:0. A write to address 9 clears exactly the requester's status bits that are 1 in the write data, and touches no other processor's status. A non-zero status also holds that processor's interrupt high.
- R10: After reset every mailbox is empty, every status and overflow flag is clear, and no interrupt, grant-free response strobe or interrupt is asserted.
- R11: An owner read of its empty mailbox returns zero with the response strobe set, and the mailbox stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | N_PROC | Request strobe, one bit per processor lane |
| req_wr | input | N_PROC | 1 = write, 0 = read, per lane |
| req_addr | input | N_PROC*ADDR_W | Register address, lane p in slice p |
| req_wdata | input | N_PROC*MSG_W | Write data, lane p in slice p |
| req_gnt | output | N_PROC | Grant for the lane served this cycle |
| rsp_vld | output | N_PROC | Response strobe, one cycle after the grant |
| rsp_rdata | output | MSG_W | Read data for the processor whose strobe is high |
| irq | output | N_PROC | Interrupt per processor: mailbox non-empty or doorbell status non-zero |

## Verification
The bench uses the default parameters: five processors, 16-bit words and 32-entry mailboxes. With these values the overflow boundary is one write past thirty-two. All eight doorbell target codes are reachable, so codes above the last processor land in the ignored range. Five lanes let a three-way collision exercise the priority order, and leave lanes outside the collision to act as non-owners and bystanders.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
   // Doorbell byte layout: target code above the interrupt number.
   localparam int BELL_NUM_W  = 3;
   localparam int BELL_TGT_W  = 3;
   localparam int BELL_TGT_LO = BELL_NUM_W;
   localparam int BELL_BITS   = 1 << BELL_NUM_W;

   // Fixed register offsets beyond the mailbox window.
   localparam int OFS_BELL = 8;
   localparam int OFS_STAT = 9;
   localparam int OFS_OVF  = 10;
endpackage

// File: rtl/ipc_prio_arb.sv
module ipc_prio_arb #(
   parameter int N    = 5,
   parameter int ID_W = 3
) (
   input  logic [N-1:0]    vld,
   output logic [N-1:0]    gnt,
   output logic [ID_W-1:0] win,
   output logic            any
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt   = '0;
      win   = '0;
      for (int i = 0; i < N; i++) begin
         if (vld[i] && !taken) begin
            gnt[i] = 1'b1;
            win    = ID_W'(i);
            taken  = 1'b1;
         end
      end
   end

   assign any = |vld;
endmodule

// File: rtl/ipc_msg_fifo.sv
module ipc_msg_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/ipc_bell_bank.sv
module ipc_bell_bank #(
   parameter int N      = 5,
   parameter int ID_W   = 3,
   parameter int NUM_W  = 3,
   parameter int BITS   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    set_en,
   input  logic [ID_W-1:0]         set_tgt,
   input  logic [NUM_W-1:0]        set_num,
   input  logic                    clr_en,
   input  logic [ID_W-1:0]         clr_who,
   input  logic [BITS-1:0]         clr_mask,
   output logic [N-1:0][BITS-1:0]  stat
);
   for (genvar p = 0; p < N; p++) begin : g_slot
      logic [BITS-1:0] set_vec, clr_vec;
      always_comb begin
         set_vec = '0;
         clr_vec = '0;
         if (set_en && set_tgt == ID_W'(p)) set_vec[set_num] = 1'b1;
         if (clr_en && clr_who == ID_W'(p)) clr_vec = clr_mask;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) stat[p] <= '0;
         else        stat[p] <= (stat[p] & ~clr_vec) | set_vec;
      end
   end
endmodule

// File: rtl/ipc_mailbox_hub.sv
module ipc_mailbox_hub #(
   parameter int N_PROC     = 5,
   parameter int MSG_W      = 16,
   parameter int MBOX_DEPTH = 32,
   parameter int ADDR_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_PROC-1:0]          req_vld,
   input  logic [N_PROC-1:0]          req_wr,
   input  logic [N_PROC*ADDR_W-1:0]   req_addr,
   input  logic [N_PROC*MSG_W-1:0]    req_wdata,
   output logic [N_PROC-1:0]          req_gnt,
   output logic [N_PROC-1:0]          rsp_vld,
   output logic [MSG_W-1:0]           rsp_rdata,
   output logic [N_PROC-1:0]          irq
);
   import ipc_pkg::*;

   localparam int ID_W = (N_PROC > 1) ? $clog2(N_PROC) : 1;
   localparam logic [ADDR_W-1:0] A_NMB  = ADDR_W'(N_PROC);
   localparam logic [ADDR_W-1:0] A_BELL = ADDR_W'(OFS_BELL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_OVF  = ADDR_W'(OFS_OVF);
   localparam logic [BELL_TGT_W-1:0] CODE_MAX = BELL_TGT_W'(N_PROC);

   initial begin
      assert (N_PROC >= 2 && N_PROC < (1 << BELL_TGT_W))
         else $fatal(1, "N_PROC must fit the doorbell target codes");
      assert (N_PROC <= OFS_BELL && ID_W <= ADDR_W && ADDR_W >= 4)
         else $fatal(1, "mailbox window overlaps fixed registers");
      assert (MSG_W >= BELL_BITS)
         else $fatal(1, "MSG_W too narrow for doorbell status");
      assert (MBOX_DEPTH >= 2)
         else $fatal(1, "MBOX_DEPTH must be at least 2");
   end

   // ---------------- arbitration and shared port ----------------
   logic [ID_W-1:0]   win_id;
   logic              win_any;
   logic              sel_wr;
   logic [ADDR_W-1:0] sel_addr;
   logic [MSG_W-1:0]  sel_data;

   ipc_prio_arb #(.N(N_PROC), .ID_W(ID_W)) u_arb (
      .vld (req_vld),
      .gnt (req_gnt),
      .win (win_id),
      .any (win_any)
   );

   assign sel_wr   = req_wr[win_id];
   assign sel_addr = req_addr[win_id*ADDR_W +: ADDR_W];
   assign sel_data = req_wdata[win_id*MSG_W +: MSG_W];

   // ---------------- decode ----------------
   logic            hit_mbox, hit_bell, hit_stat, hit_ovf, own_mbox;
   logic [ID_W-1:0] mb_idx;
   logic [BELL_TGT_W-1:0] bell_code;
   logic [BELL_NUM_W-1:0] bell_num;
   logic            bell_ok;

   assign hit_mbox  = win_any && (sel_addr < A_NMB);
   assign hit_bell  = win_any && (sel_addr == A_BELL);
   assign hit_stat  = win_any && (sel_addr == A_STAT);
   assign hit_ovf   = win_any && (sel_addr == A_OVF);
   assign mb_idx    = sel_addr[ID_W-1:0];
   assign own_mbox  = hit_mbox && (mb_idx == win_id);
   assign bell_code = sel_data[BELL_TGT_LO +: BELL_TGT_W];
   assign bell_num  = sel_data[BELL_NUM_W-1:0];
   assign bell_ok   = (bell_code != '0) && (bell_code <= CODE_MAX);

   // ---------------- mailboxes ----------------
   logic [N_PROC-1:0]            mb_push, mb_pop, mb_empty, mb_full, ovf_flag;
   logic [N_PROC-1:0][MSG_W-1:0] mb_dout;
   logic                          ovf_clr;

   assign ovf_clr = hit_ovf && sel_wr && sel_data[0];

   for (genvar k = 0; k < N_PROC; k++) begin : g_mbox
      assign mb_push[k] = hit_mbox && sel_wr && (mb_idx == ID_W'(k));
      assign mb_pop[k]  = own_mbox && !sel_wr && (mb_idx == ID_W'(k));

      ipc_msg_fifo #(.W(MSG_W), .DEPTH(MBOX_DEPTH)) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (mb_push[k]),
         .din   (sel_data),
         .pop   (mb_pop[k]),
         .dout  (mb_dout[k]),
         .empty (mb_empty[k]),
         .full  (mb_full[k])
      );

      always_ff @(posedge clk) begin
         if (!rst_n)                        ovf_flag[k] <= 1'b0;
         else if (mb_push[k] && mb_full[k]) ovf_flag[k] <= 1'b1;
         else if (ovf_clr && win_id == ID_W'(k)) ovf_flag[k] <= 1'b0;
      end
   end

   // ---------------- doorbells ----------------
   logic [N_PROC-1:0][BELL_BITS-1:0] bell_stat;
   logic [ID_W-1:0] bell_tgt;

   assign bell_tgt = ID_W'(bell_code - 1'b1);

   ipc_bell_bank #(
      .N(N_PROC), .ID_W(ID_W), .NUM_W(BELL_NUM_W), .BITS(BELL_BITS)
   ) u_bell (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (hit_bell && sel_wr && bell_ok),
      .set_tgt  (bell_tgt),
      .set_num  (bell_num),
      .clr_en   (hit_stat && sel_wr),
      .clr_who  (win_id),
      .clr_mask (sel_data[BELL_BITS-1:0]),
      .stat     (bell_stat)
   );

   // ---------------- response ----------------
   logic [MSG_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (win_any && !sel_wr) begin
         if (own_mbox)
            rd_next = mb_empty[win_id] ? '0 : mb_dout[win_id];
         else if (hit_stat)
            rd_next = MSG_W'(bell_stat[win_id]);
         else if (hit_ovf)
            rd_next = MSG_W'(ovf_flag[win_id]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld   <= '0;
         rsp_rdata <= '0;
      end else begin
         rsp_vld   <= req_gnt;
         rsp_rdata <= rd_next;
      end
   end

   for (genvar p = 0; p < N_PROC; p++) begin : g_irq
      assign irq[p] = !mb_empty[p] || (bell_stat[p] != '0);
   end
endmodule

// File: rtl/ipc_mailbox_hub_chk.sv
module ipc_mailbox_hub_chk #(
   parameter int N_PROC = 5,
   parameter int ADDR_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [N_PROC-1:0]        req_vld,
   input logic [N_PROC-1:0]        req_wr,
   input logic [N_PROC*ADDR_W-1:0] req_addr,
   input logic [N_PROC-1:0]        req_gnt,
   input logic [N_PROC-1:0]        rsp_vld,
   input logic [N_PROC-1:0]        irq,
   input logic [N_PROC-1:0]        mb_full,
   input logic [N_PROC-1:0]        ovf_flag
);
   a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_gnt));

   a_r1_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      (req_gnt & ~req_vld) == '0);

   a_r1_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld != '0) |-> (req_gnt != '0));

   a_r3_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req_gnt != '0) |=> (rsp_vld == $past(req_gnt)));

   a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (irq == '0 && rsp_vld == '0));

   for (genvar k = 0; k < N_PROC; k++) begin : g_box
      a_r5_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ovf_flag[k]) |-> $past(mb_full[k]));

      for (genvar i = 0; i < N_PROC; i++) begin : g_lane
         a_r6_write_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (req_gnt[i] && req_wr[i] && req_addr[i*ADDR_W +: ADDR_W] == ADDR_W'(k))
            |=> irq[k]);
      end
   end
endmodule

bind ipc_mailbox_hub ipc_mailbox_hub_chk #(.N_PROC(N_PROC), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vld  (req_vld),
   .req_wr   (req_wr),
   .req_addr (req_addr),
   .req_gnt  (req_gnt),
   .rsp_vld  (rsp_vld),
   .irq      (irq),
   .mb_full  (mb_full),
   .ovf_flag (ovf_flag)
);

// File: tb/ipc_mailbox_hub_bench.sv
module ipc_mailbox_hub_bench;
   localparam int NP = 5;
   localparam int MW = 16;
   localparam int DP = 32;
   localparam int AW = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP-1:0]     req_vld = '0;
   logic [NP-1:0]     req_wr = '0;
   logic [NP*AW-1:0]  req_addr = '0;
   logic [NP*MW-1:0]  req_wdata = '0;
   logic [NP-1:0]     req_gnt, rsp_vld, irq;
   logic [MW-1:0]     rsp_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ipc_mailbox_hub #(.N_PROC(NP), .MSG_W(MW), .MBOX_DEPTH(DP), .ADDR_W(AW)) u_ipc_mailbox_hub (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_gnt(req_gnt),
      .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic lane_set(input int id, input bit wr, input int addr, input int data);
      req_vld[id] = 1'b1;
      req_wr[id]  = wr;
      req_addr[id*AW +: AW] = AW'(addr);
      req_wdata[id*MW +: MW] = MW'(data);
   endtask

   task automatic lane_clr(input int id);
      req_vld[id] = 1'b0;
      req_wr[id]  = 1'b0;
      req_addr[id*AW +: AW] = '0;
      req_wdata[id*MW +: MW] = '0;
   endtask

   // One single-lane access; returns at the negedge after the response register loads.
   task automatic op(input int id, input bit wr, input int addr, input int data,
                     output logic [MW-1:0] rd, output logic v);
      @(negedge clk);
      lane_set(id, wr, addr, data);
      @(posedge clk);
      @(negedge clk);
      lane_clr(id);
      rd = rsp_rdata;
      v  = rsp_vld[id];
   endtask

   task automatic wr_op(input int id, input int addr, input int data);
      logic [MW-1:0] d; logic v;
      op(id, 1'b1, addr, data, d, v);
   endtask

   task automatic rd_op(input int id, input int addr, output logic [MW-1:0] d);
      logic v;
      op(id, 1'b0, addr, 0, d, v);
   endtask

   task automatic t_reset;
      logic [MW-1:0] d;
      chk("R10 irq after reset", irq, '0);
      chk("R10 rsp_vld after reset", rsp_vld, '0);
      chk("R10 grant idle", req_gnt, '0);
      rd_op(0, 9, d);  chk("R10 status clear", d, 0);
      rd_op(3, 10, d); chk("R10 overflow clear", d, 0);
   endtask

   task automatic t_mbox_basic;
      logic [MW-1:0] d; logic v;
      wr_op(2, 1, 16'hA1B2);
      chk("R6 irq after first write", irq, 5'b00010);
      wr_op(4, 1, 16'h0C0D);
      op(1, 1'b0, 1, 0, d, v);
      chk("R3 strobe on owner read", v, 1);
      chk("R3 first word", d, 16'hA1B2);
      chk("R6 irq held while data left", irq[1], 1);
      rd_op(1, 1, d); chk("R3 second word in order", d, 16'h0C0D);
      chk("R6 irq drops when empty", irq, '0);
      op(1, 1'b0, 1, 0, d, v);
      chk("R11 empty read strobe", v, 1);
      chk("R11 empty read data", d, 0);
      chk("R11 stays empty", irq, '0);
   endtask

   task automatic t_nonowner;
      logic [MW-1:0] d;
      wr_op(0, 3, 16'h1234);
      rd_op(2, 3, d); chk("R4 non-owner read zero", d, 0);
      chk("R4 mailbox kept", irq, 5'b01000);
      rd_op(3, 3, d); chk("R4 word survives for owner", d, 16'h1234);
      chk("R4 drained by owner", irq, '0);
   endtask

   task automatic t_full;
      logic [MW-1:0] d;
      for (int i = 0; i < DP; i++) wr_op(1, 4, 16'h0100 + i);
      rd_op(4, 10, d); chk("R5 no overflow at exactly full", d, 0);
      wr_op(0, 4, 16'hDEAD);
      rd_op(4, 10, d); chk("R5 overflow set", d, 1);
      rd_op(0, 10, d); chk("R5 other owner flag clear", d, 0);
      for (int i = 0; i < DP; i++) begin
         rd_op(4, 4, d);
         chk($sformatf("R2 word %0d of full mailbox", i), d, 16'h0100 + i);
      end
      chk("R5 dropped word not stored", irq, '0);
      rd_op(4, 4, d); chk("R11 empty after drain", d, 0);
      rd_op(4, 10, d); chk("R5 overflow sticky", d, 1);
      wr_op(2, 10, 1);
      rd_op(4, 10, d); chk("R5 other clear leaves flag", d, 1);
      wr_op(4, 10, 1);
      rd_op(4, 10, d); chk("R5 owner clears flag", d, 0);
   endtask

   task automatic t_bell;
      logic [MW-1:0] d;
      wr_op(0, 8, 8'hC0 | (3 << 3) | 5);
      chk("R7 target irq", irq, 5'b00100);
      rd_op(2, 9, d); chk("R7 status bit set, 7:6 ignored", d, 16'h0020);
      rd_op(1, 9, d); chk("R9 neighbour status untouched", d, 0);
      wr_op(4, 8, (3 << 3) | 0);
      rd_op(2, 9, d); chk("R7 second bit accumulates", d, 16'h0021);
      wr_op(1, 9, 16'h00FF);
      rd_op(2, 9, d); chk("R9 clear by other has no effect", d, 16'h0021);
      wr_op(2, 9, 16'h0020);
      rd_op(2, 9, d); chk("R9 write-one clears only that bit", d, 16'h0001);
      chk("R9 irq held by status", irq[2], 1);
      wr_op(2, 9, 16'h0001);
      chk("R9 irq released", irq, '0);
      wr_op(3, 8, (1 << 3) | 7);
      wr_op(3, 8, (5 << 3) | 1);
      chk("R7 codes 1 and 5 map to first and last", irq, 5'b10001);
      rd_op(0, 9, d); chk("R7 code 1 bit 7", d, 16'h0080);
      rd_op(4, 9, d); chk("R7 code 5 bit 1", d, 16'h0002);
      wr_op(0, 9, 16'h00FF);
      wr_op(4, 9, 16'h00FF);
      chk("R9 all cleared", irq, '0);
   endtask

   task automatic t_bad_code;
      logic [MW-1:0] d;
      wr_op(1, 8, (0 << 3) | 2);
      wr_op(1, 8, (6 << 3) | 3);
      wr_op(1, 8, (7 << 3) | 4);
      chk("R8 no irq from ignored codes", irq, '0);
      for (int p = 0; p < NP; p++) begin
         rd_op(p, 9, d);
         chk($sformatf("R8 status of processor %0d", p), d, 0);
      end
   endtask

   task automatic t_arb;
      logic [MW-1:0] d;
      @(negedge clk);
      lane_set(1, 1'b1, 0, 16'h0011);
      lane_set(3, 1'b1, 0, 16'h0033);
      lane_set(4, 1'b1, 0, 16'h0044);
      #1 chk("R1 lowest lane wins", req_gnt, 5'b00010);
      @(posedge clk); @(negedge clk);
      lane_clr(1);
      #1 chk("R1 next lane served", req_gnt, 5'b01000);
      chk("R3 strobe for first winner", rsp_vld, 5'b00010);
      @(posedge clk); @(negedge clk);
      lane_clr(3);
      #1 chk("R1 last lane served", req_gnt, 5'b10000);
      @(posedge clk); @(negedge clk);
      lane_clr(4);
      #1 chk("R1 idle after all served", req_gnt, '0);
      rd_op(0, 0, d); chk("R1 order word 1", d, 16'h0011);
      rd_op(0, 0, d); chk("R1 order word 2", d, 16'h0033);
      rd_op(0, 0, d); chk("R1 order word 3", d, 16'h0044);
      chk("R1 mailbox drained", irq, '0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset;
      t_mbox_basic;
      t_nonowner;
      t_full;
      t_bell;
      t_bad_code;
      t_arb;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule